// File: doc/BRIEF.md
# Eviction Bucket-Clear Decision Unit

When a cache set loses a block, through replacement or through an invalidation, the coherence directory may be able to drop that block's trace from its hashed presence filters. The directory keeps one bucket per hash table for each cache set. A bucket can only be emptied when no block that stays in the set still lands on it. This unit sits on the cache side and makes that decision. It uses the tags of the whole set, which were already read by the normal access, together with their valid bits and the index of the departing way.

Every hash table's function is applied to every way of the set at the same time. Each surviving valid way's bucket is compared with the departing block's bucket, one comparison per table. The result is one clear-permission bit per hash table. That mask is registered and presented one cycle after the eviction strobe, together with a one-cycle valid pulse, ready to ride in the eviction or invalidate-acknowledge message.

Top module: `dirfc_evict_clear`

## Requirements
- R1: `clr_vld` is high in exactly the cycle after each cycle in which `evict_vld` is sampled high, and low otherwise.
- R2: For a strobe with a valid departing way, bit t of `clr_mask` is 1 exactly when no other valid way of the set has the same table-t bucket as the departing tag.
- R3: Ways whose valid bit is 0 never block a clear, even when their tag matches the departing tag.
- R4: The departing way is never compared with itself. A departing way that is the only valid way yields an all-ones mask.
- R5: A strobe whose departing way has its valid bit at 0 yields an all-zero mask.
- R6: `clr_mask` holds its value in cycles without a strobe, whatever the tag, valid and way inputs do.
- R7: After reset, `clr_vld` and `clr_mask` are 0.
- R8: The table-t bucket of a tag is computed in three steps. First the tag is rotated right by 3*t bits. Then it is split into 6-bit chunks, with bits [5:0] as chunk 0 and the top chunk zero-padded. The bucket is the XOR of those chunks. A surviving way with a tag equal to the departing tag therefore clears every bit of the mask.
- R9: Strobes on consecutive cycles each produce their own result in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evict_vld | input | 1 | Eviction or invalidation strobe for the presented set |
| evict_way | input | $clog2(WAYS) | Index of the departing way |
| set_tags | input | WAYS*TAG_W | Tags of all ways; way w at bits [w*TAG_W +: TAG_W] |
| set_valid | input | WAYS | Valid bit of each way |
| clr_vld | output | 1 | One-cycle pulse marking a fresh mask |
| clr_mask | output | NTAB | Per-table clear permission, bit t for table t |

## Verification
Directed patterns come first, and each one separates a single rule. A lone valid way shows whether the departing way is wrongly compared with itself. An exact duplicate tag in a surviving way shows whether all tables see the conflict. The same duplicate placed in an invalid way shows whether valid bits gate the comparison. A departing way with its valid bit at 0 must give an all-zero mask. Random sets with random tags, random valid patterns and random departing ways then produce partial masks, where only some tables collide, and these check each table's hash separately. Idle cycles with changing inputs between strobes show that the mask holds, and back-to-back strobes show that results are not mixed up across cycles.

// File: rtl/dirfc_pkg.sv
// Package: default geometry of the eviction bucket-clear unit.
// Assumes one tag per way with no extra state bits folded into the hash.
package dirfc_pkg;
    localparam int DEF_WAYS     = 16;
    localparam int DEF_TAG_W    = 32;
    localparam int DEF_BKT_W    = 6;
    localparam int DEF_NTAB     = 4;
    localparam int DEF_ROT_STEP = 3;
endpackage

// File: rtl/dirfc_hash.sv
// Module: applies every directory hash table's function to one tag.
// Table t rotates the tag right by ROT_STEP*t bits and XOR-folds it into
// BKT_W-bit chunks (top chunk zero-padded). Must match the directory's hashes.
module dirfc_hash #(
    parameter int TAG_W    = dirfc_pkg::DEF_TAG_W,
    parameter int BKT_W    = dirfc_pkg::DEF_BKT_W,
    parameter int NTAB     = dirfc_pkg::DEF_NTAB,
    parameter int ROT_STEP = dirfc_pkg::DEF_ROT_STEP
) (
    input  logic [TAG_W-1:0]      tag,
    output logic [NTAB*BKT_W-1:0] bkt
);
    localparam int NCHUNK = (TAG_W + BKT_W - 1) / BKT_W;

    logic [2*TAG_W-1:0] dbl;
    assign dbl = {tag, tag};

    for (genvar t = 0; t < NTAB; t++) begin : g_tab
        localparam int ROT = (ROT_STEP * t) % TAG_W;
        logic [NCHUNK*BKT_W-1:0] padded;
        logic [BKT_W-1:0]        fold;

        // Rotate the tag and pad it to a whole number of chunks.
        always_comb begin
            padded             = '0;
            padded[TAG_W-1:0]  = dbl[ROT +: TAG_W];
        end

        // XOR all chunks together into the bucket index.
        always_comb begin
            fold = '0;
            for (int c = 0; c < NCHUNK; c++) begin
                fold = fold ^ padded[c*BKT_W +: BKT_W];
            end
        end

        assign bkt[t*BKT_W +: BKT_W] = fold;
    end
endmodule

// File: rtl/dirfc_match.sv
// Module: for one hash table, reports whether any surviving way lands on
// the departing block's bucket. Assumes `survivor` already excludes the
// departing way and invalid ways.
module dirfc_match #(
    parameter int WAYS  = dirfc_pkg::DEF_WAYS,
    parameter int BKT_W = dirfc_pkg::DEF_BKT_W
) (
    input  logic [WAYS*BKT_W-1:0] way_bkt,
    input  logic [BKT_W-1:0]      dep_bkt,
    input  logic [WAYS-1:0]       survivor,
    output logic                  conflict
);
    logic [WAYS-1:0] hit;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit[w] = survivor[w] && (way_bkt[w*BKT_W +: BKT_W] == dep_bkt);
    end

    assign conflict = |hit;
endmodule

// File: rtl/dirfc_evict_clear.sv
// Module: top of the eviction bucket-clear decision unit.
// Assumes the whole set's tags and valid bits are presented with the strobe
// (one set checked, inclusive cache). Mask and valid pulse are registered.
module dirfc_evict_clear #(
    parameter int WAYS     = dirfc_pkg::DEF_WAYS,
    parameter int TAG_W    = dirfc_pkg::DEF_TAG_W,
    parameter int BKT_W    = dirfc_pkg::DEF_BKT_W,
    parameter int NTAB     = dirfc_pkg::DEF_NTAB,
    parameter int ROT_STEP = dirfc_pkg::DEF_ROT_STEP,
    localparam int WAY_W   = $clog2(WAYS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  evict_vld,
    input  logic [WAY_W-1:0]      evict_way,
    input  logic [WAYS*TAG_W-1:0] set_tags,
    input  logic [WAYS-1:0]       set_valid,
    output logic                  clr_vld,
    output logic [NTAB-1:0]       clr_mask
);
    logic [NTAB*BKT_W-1:0] bkt_all [WAYS];
    logic [NTAB*BKT_W-1:0] dep_bkt;
    logic [WAYS-1:0]       dep_onehot;
    logic [WAYS-1:0]       survivor;
    logic                  dep_valid;
    logic [NTAB-1:0]       conflict;
    logic [NTAB-1:0]       mask_nxt;

    // Hash replicas, one per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        dirfc_hash #(
            .TAG_W(TAG_W), .BKT_W(BKT_W), .NTAB(NTAB), .ROT_STEP(ROT_STEP)
        ) u_hash (
            .tag (set_tags[w*TAG_W +: TAG_W]),
            .bkt (bkt_all[w])
        );
    end

    // Decode the departing way into a one-hot mask.
    always_comb begin
        dep_onehot = '0;
        dep_onehot[evict_way] = 1'b1;
    end

    assign dep_bkt   = bkt_all[evict_way];
    assign dep_valid = set_valid[evict_way];
    assign survivor  = set_valid & ~dep_onehot;

    // Per-table comparison across all surviving ways.
    for (genvar t = 0; t < NTAB; t++) begin : g_tab
        logic [WAYS*BKT_W-1:0] col;
        for (genvar w = 0; w < WAYS; w++) begin : g_col
            assign col[w*BKT_W +: BKT_W] = bkt_all[w][t*BKT_W +: BKT_W];
        end
        dirfc_match #(.WAYS(WAYS), .BKT_W(BKT_W)) u_match (
            .way_bkt  (col),
            .dep_bkt  (dep_bkt[t*BKT_W +: BKT_W]),
            .survivor (survivor),
            .conflict (conflict[t])
        );
    end

    // Clear permission: only for a valid departing block, per table.
    assign mask_nxt = dep_valid ? ~conflict : '0;

    // Register the mask on a strobe and pulse the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_vld  <= 1'b0;
            clr_mask <= '0;
        end else begin
            clr_vld <= evict_vld;
            if (evict_vld) begin
                clr_mask <= mask_nxt;
            end
        end
    end
endmodule

// File: rtl/dirfc_evict_clear_chk.sv
// Checker: temporal properties of the eviction bucket-clear unit, bound
// to every instance of the top module.
module dirfc_evict_clear_chk #(
    parameter int WAYS = dirfc_pkg::DEF_WAYS,
    parameter int NTAB = dirfc_pkg::DEF_NTAB,
    localparam int WAY_W = $clog2(WAYS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evict_vld,
    input logic [WAY_W-1:0] evict_way,
    input logic [WAYS-1:0]  set_valid,
    input logic             clr_vld,
    input logic [NTAB-1:0]  clr_mask
);
    assert_pulse_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        evict_vld |=> clr_vld);

    assert_no_spurious_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !evict_vld |=> !clr_vld);

    assert_sole_valid_all_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_vld && set_valid[evict_way] && $countones(set_valid) == 1)
        |=> (&clr_mask));

    assert_invalid_dep_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_vld && !set_valid[evict_way]) |=> (clr_mask == '0));

    assert_mask_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !evict_vld |=> $stable(clr_mask));
endmodule

bind dirfc_evict_clear dirfc_evict_clear_chk #(.WAYS(WAYS), .NTAB(NTAB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evict_vld (evict_vld),
    .evict_way (evict_way),
    .set_valid (set_valid),
    .clr_vld   (clr_vld),
    .clr_mask  (clr_mask)
);

// File: tb/sim_dirfc_evict_clear.sv
module sim_dirfc_evict_clear;
    localparam int WAYS  = 16;
    localparam int TAG_W = 32;
    localparam int BKT_W = 6;
    localparam int NTAB  = 4;
    localparam int WAY_W = 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  evict_vld = 1'b0;
    logic [WAY_W-1:0]      evict_way = '0;
    logic [WAYS*TAG_W-1:0] set_tags = '0;
    logic [WAYS-1:0]       set_valid = '0;
    logic                  clr_vld;
    logic [NTAB-1:0]       clr_mask;

    int n_run  = 0;
    int n_fail = 0;
    logic [TAG_W-1:0] tg [WAYS];

    always #2 clk = ~clk;

    dirfc_evict_clear u0 (
        .clk(clk), .rst_n(rst_n), .evict_vld(evict_vld), .evict_way(evict_way),
        .set_tags(set_tags), .set_valid(set_valid),
        .clr_vld(clr_vld), .clr_mask(clr_mask)
    );

    // Bucket by bit membership: tag bit i lands on bucket bit ((i-3t) mod 32) % 6 (R8).
    function automatic logic [BKT_W-1:0] ref_bucket(logic [TAG_W-1:0] tag, int t);
        logic [BKT_W-1:0] b = '0;
        for (int i = 0; i < TAG_W; i++) begin
            int pos = (i - 3*t + TAG_W) % TAG_W;
            b[pos % BKT_W] ^= tag[i];
        end
        return b;
    endfunction

    function automatic logic [NTAB-1:0] ref_mask(int dep);
        logic [NTAB-1:0] m;
        if (!set_valid[dep]) return '0;
        m = '1;
        for (int t = 0; t < NTAB; t++)
            for (int w = 0; w < WAYS; w++)
                if (w != dep && set_valid[w] && ref_bucket(tg[w], t) == ref_bucket(tg[dep], t))
                    m[t] = 1'b0;
        return m;
    endfunction

    task automatic pack();
        for (int w = 0; w < WAYS; w++) set_tags[w*TAG_W +: TAG_W] = tg[w];
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Strobe once (inputs set by caller), then check the registered result.
    task automatic strobe(string req, int dep);
        logic [NTAB-1:0] e;
        pack();
        evict_way = dep[WAY_W-1:0];
        evict_vld = 1'b1;
        e = ref_mask(dep);
        @(posedge clk); @(negedge clk);
        check({req, " vld"}, 32'(clr_vld), 32'd1);
        check({req, " mask"}, 32'(clr_mask), 32'(e));
    endtask

    task automatic idle_scramble(logic [NTAB-1:0] hold);
        evict_vld = 1'b0;
        for (int w = 0; w < WAYS; w++) tg[w] = $urandom;
        pack();
        set_valid = WAYS'($urandom);
        evict_way = WAY_W'($urandom);
        @(posedge clk); @(negedge clk);
        check("R1 no pulse", 32'(clr_vld), 32'd0);
        check("R6 hold", 32'(clr_mask), 32'(hold));
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int w = 0; w < WAYS; w++) tg[w] = 32'h1000_0000 + w * 32'h0101_0107;
        repeat (3) @(negedge clk);
        check("R7 vld", 32'(clr_vld), 32'd0);
        check("R7 mask", 32'(clr_mask), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: sole valid way
        set_valid = 16'h0020;
        strobe("R4 sole", 5);
        check("R4 ones", 32'(clr_mask), 32'hF);
        // R8: valid duplicate tag blocks every table
        tg[9] = tg[5]; set_valid = 16'h0220;
        strobe("R8 dup", 5);
        check("R8 zero", 32'(clr_mask), 32'h0);
        // R3: duplicate in an invalid way is ignored
        set_valid = 16'h0020;
        strobe("R3 inv dup", 5);
        check("R3 ones", 32'(clr_mask), 32'hF);
        // R5: invalid departing way
        set_valid = 16'hFFDF;
        strobe("R5 inv dep", 5);
        check("R5 zero", 32'(clr_mask), 32'h0);
        // R4 again then R6 hold across scrambled idle inputs
        for (int w = 0; w < WAYS; w++) tg[w] = 32'h0;
        tg[0] = 32'hDEAD_BEEF; set_valid = 16'h0001;
        strobe("R4 way0", 0);
        idle_scramble(4'hF);
        idle_scramble(4'hF);

        // R2/R9: random back-to-back strobes, with occasional idle gaps
        for (int n = 0; n < 400; n++) begin
            for (int w = 0; w < WAYS; w++) tg[w] = $urandom;
            if (n % 5 == 0) tg[$urandom % WAYS] = tg[$urandom % WAYS];
            set_valid = WAYS'($urandom) | WAYS'($urandom);
            strobe((n % 2 == 0) ? "R2 rand" : "R9 b2b", int'($urandom % WAYS));
            if (n % 37 == 0) idle_scramble(clr_mask);
        end
        evict_vld = 1'b0;
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule